// File: doc/BRIEF.md
# Variable-Length Signed Dot Product

This block takes two vectors of eight signed 8-bit elements and returns the sum of the pairwise products over a leading run of elements. The run length is a 3-bit input and can change from cycle to cycle. Loop bounds in hardware cannot depend on a signal. For that reason the block always builds every product and every running sum. The length code only steers a multiplexer that picks one of the running sums.

Each element pair goes through its own signed multiplier. The product is widened to the 32-bit result width. A chain of adders then forms the running sums: running sum k is running sum k-1 plus product k. A parameter of enumerated type chooses the output variant. In the registered variant, the selected sum is captured on the rising clock edge and a synchronous reset clears it. In the combinational variant, the selected sum drives the output directly. The default is the registered variant.

Top module: `vdot_unit`

## Requirements
- R1: Element k of each vector sits in bits [8k+7:8k] of that vector, so element 0 is the least significant byte. Every element is a two's-complement signed value.
- R2: A length code n from 1 to 7 gives the sum of the products of elements 0 through n-1.
- R3: A length code of 0 gives the sum of all eight products.
- R4: Elements at positions equal to or above the selected length never change the result, whatever their values.
- R5: Each product is sign-extended to 32 bits before it is added. The result is the exact signed sum. For example, eight products of -128 by -128 give 131072, and eight products of -128 by 127 give -130048.
- R6: In the registered variant, the output takes the value computed from the inputs present at a rising clock edge, just after that edge. It holds that value until the next edge.
- R7: In the registered variant, a synchronous reset high at a rising edge sets the output to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| vec_a | input | 64 | First vector, eight packed signed bytes |
| vec_b | input | 64 | Second vector, eight packed signed bytes |
| len_code | input | 3 | Number of leading terms to sum; 0 means all eight |
| dot_out | output | 32 | Signed dot product, two's complement |

## Verification
Each fault has its own signature at the output. A wrong tap in the length multiplexer moves the result by exactly one product, and it does so for every length code that selects that tap. A missing sign extension only shows when a negative product is summed, so vectors that mix signs and use extreme values are needed to expose it. A broken link in the adder chain corrupts every longer length, while shorter lengths stay correct. In the registered variant, every one of these errors appears one clock edge after the offending inputs are applied.

// File: rtl/vdot_pkg.sv
package vdot_pkg;

    // Output variant of the dot product unit
    typedef enum logic [0:0] {
        OUT_COMB = 1'b0,
        OUT_REG  = 1'b1
    } vdot_out_mode_e;

    localparam int VDOT_ELEM_W = 8;
    localparam int VDOT_LANES  = 8;
    localparam int VDOT_ACC_W  = 32;

endpackage

// File: rtl/vdot_mul_lane.sv
module vdot_mul_lane #(
    parameter int ELEM_W = 8,
    parameter int ACC_W  = 32
) (
    input  logic [ELEM_W-1:0] elem_a,
    input  logic [ELEM_W-1:0] elem_b,
    output logic [ACC_W-1:0]  prod
);
    localparam int PROD_W = 2 * ELEM_W;
    localparam int EXT_W  = ACC_W - PROD_W;

    logic signed [PROD_W-1:0] raw_prod;

    always_comb begin
        raw_prod = $signed(elem_a) * $signed(elem_b);
    end

    assign prod = {{EXT_W{raw_prod[PROD_W-1]}}, raw_prod};

    // Sign of a nonzero product follows the operand signs
    always_comb begin
        if (elem_a != '0 && elem_b != '0) begin
            AST_PROD_SIGN: assert (prod[ACC_W-1] == (elem_a[ELEM_W-1] ^ elem_b[ELEM_W-1])); // R5
        end
    end

endmodule

// File: rtl/vdot_prefix_chain.sv
module vdot_prefix_chain #(
    parameter int LANES  = 8,
    parameter int ELEM_W = 8,
    parameter int ACC_W  = 32
) (
    input  logic [LANES*ACC_W-1:0] prod_flat,
    output logic [LANES*ACC_W-1:0] prefix_flat
);
    localparam longint MAX_POS = longint'(LANES) * (longint'(1) << (2*ELEM_W - 2));
    localparam longint MIN_NEG = -longint'(LANES) * ((longint'(1) << (2*ELEM_W - 2)) - (longint'(1) << (ELEM_W - 1)));

    assign prefix_flat[ACC_W-1:0] = prod_flat[ACC_W-1:0];

    for (genvar k = 1; k < LANES; k++) begin : g_step
        assign prefix_flat[k*ACC_W +: ACC_W] =
            prefix_flat[(k-1)*ACC_W +: ACC_W] + prod_flat[k*ACC_W +: ACC_W];
    end

    // Full sum stays inside the range reachable by eight products
    always_comb begin
        AST_NO_OVERFLOW: assert (
            longint'($signed(prefix_flat[(LANES-1)*ACC_W +: ACC_W])) <= MAX_POS &&
            longint'($signed(prefix_flat[(LANES-1)*ACC_W +: ACC_W])) >= MIN_NEG); // R5
    end

endmodule

// File: rtl/vdot_len_sel.sv
module vdot_len_sel #(
    parameter int LANES = 8,
    parameter int ACC_W = 32
) (
    input  logic [LANES*ACC_W-1:0]     prefix_flat,
    input  logic [$clog2(LANES)-1:0]   len_code,
    output logic [ACC_W-1:0]           sel_sum
);
    localparam int LEN_W = $clog2(LANES);

    logic [LEN_W-1:0] tap_idx;

    always_comb begin
        if (len_code == '0) begin
            tap_idx = LEN_W'(LANES - 1);
        end else begin
            tap_idx = len_code - LEN_W'(1);
        end
        sel_sum = prefix_flat[tap_idx*ACC_W +: ACC_W];
    end

endmodule

// File: rtl/vdot_unit.sv
module vdot_unit
    import vdot_pkg::*;
#(
    parameter int             ELEM_W   = VDOT_ELEM_W,
    parameter int             LANES    = VDOT_LANES,
    parameter int             ACC_W    = VDOT_ACC_W,
    parameter vdot_out_mode_e OUT_MODE = OUT_REG
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [LANES*ELEM_W-1:0]   vec_a,
    input  logic [LANES*ELEM_W-1:0]   vec_b,
    input  logic [$clog2(LANES)-1:0]  len_code,
    output logic [ACC_W-1:0]          dot_out
);
    localparam int LEN_W = $clog2(LANES);

    logic [LANES*ACC_W-1:0] prod_flat;
    logic [LANES*ACC_W-1:0] prefix_flat;
    logic [ACC_W-1:0]       sel_sum;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        vdot_mul_lane #(
            .ELEM_W (ELEM_W),
            .ACC_W  (ACC_W)
        ) u_lane (
            .elem_a (vec_a[k*ELEM_W +: ELEM_W]),
            .elem_b (vec_b[k*ELEM_W +: ELEM_W]),
            .prod   (prod_flat[k*ACC_W +: ACC_W])
        );
    end

    vdot_prefix_chain #(
        .LANES  (LANES),
        .ELEM_W (ELEM_W),
        .ACC_W  (ACC_W)
    ) u_chain (
        .prod_flat   (prod_flat),
        .prefix_flat (prefix_flat)
    );

    vdot_len_sel #(
        .LANES (LANES),
        .ACC_W (ACC_W)
    ) u_sel (
        .prefix_flat (prefix_flat),
        .len_code    (len_code),
        .sel_sum     (sel_sum)
    );

    if (OUT_MODE == OUT_REG) begin : g_reg_out
        logic [ACC_W-1:0] dot_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                dot_q <= '0;
            end else begin
                dot_q <= sel_sum;
            end
        end
        assign dot_out = dot_q;
    end else begin : g_comb_out
        assign dot_out = sel_sum;
    end

    // A single-term length reduces to the product of the first lane
    AST_LEN1_FIRST_TERM: assert property (@(posedge clk) disable iff (rst)
        (len_code == LEN_W'(1)) |-> (sel_sum == prod_flat[ACC_W-1:0])); // R2

    // Changing only the tail beyond length one leaves the selected sum unchanged
    AST_TAIL_IGNORED: assert property (@(posedge clk) disable iff (rst)
        ((len_code == LEN_W'(1)) && $stable(len_code) &&
         $stable(vec_a[ELEM_W-1:0]) && $stable(vec_b[ELEM_W-1:0])) |-> $stable(sel_sum)); // R4

endmodule

// File: tb/vdot_unit_tb.sv
`timescale 1ns/1ps
module vdot_unit_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] vec_a;
    logic [63:0] vec_b;
    logic [2:0]  len_code;
    logic [31:0] dot_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    vdot_unit u_dut (
        .clk      (clk),
        .rst      (rst),
        .vec_a    (vec_a),
        .vec_b    (vec_b),
        .len_code (len_code),
        .dot_out  (dot_out)
    );

    typedef struct packed {
        logic [63:0] a;
        logic [63:0] b;
        logic [2:0]  len;
    } vec_t;

    localparam int N_VEC = 9;
    localparam vec_t VEC_TAB [N_VEC] = '{
        '{64'h0101010101010101, 64'h0101010101010101, 3'd0},
        '{64'h0101010101010101, 64'h0101010101010101, 3'd5},
        '{64'h8080808080808080, 64'h8080808080808080, 3'd0},
        '{64'h8080808080808080, 64'h7F7F7F7F7F7F7F7F, 3'd0},
        '{64'h0807060504030201, 64'h0202020202020202, 3'd3},
        '{64'h0807060504030201, 64'h0202020202020202, 3'd1},
        '{64'h7F01010101010101, 64'h7F02020202020202, 3'd7},
        '{64'hFF01FF01FF01FF01, 64'h0303030303030303, 3'd0},
        '{64'hFF01FF01FF01FF01, 64'h0303030303030303, 3'd3}
    };

    // Expected value from the requirements: signed bytes, low byte first
    function automatic logic [31:0] ref_dot(input logic [63:0] a, input logic [63:0] b,
                                            input logic [2:0] len);
        int terms;
        int acc;
        terms = (len == 3'd0) ? 8 : int'(len);
        acc = 0;
        for (int k = 0; k < terms; k++) begin
            acc += int'($signed(a[k*8 +: 8])) * int'($signed(b[k*8 +: 8]));
        end
        return acc;
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, $signed(act), $signed(exp));
        end
    endtask

    task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic [2:0] len);
        @(negedge clk);
        vec_a = a;
        vec_b = b;
        len_code = len;
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1;
        vec_a = '0;
        vec_b = '0;
        len_code = '0;
        repeat (3) @(negedge clk);
        check(dot_out, 32'd0, "R7 reset state");
        rst = 1'b0;

        // Table walk: R1 packing, R2 leading terms, R3 full length, R5 signs
        for (int i = 0; i < N_VEC; i++) begin
            apply(VEC_TAB[i].a, VEC_TAB[i].b, VEC_TAB[i].len);
            check(dot_out, ref_dot(VEC_TAB[i].a, VEC_TAB[i].b, VEC_TAB[i].len), "R1/R2/R3 table");
        end

        // Hand-worked values
        apply(64'h8080808080808080, 64'h8080808080808080, 3'd0);
        check(dot_out, 32'd131072, "R5 max positive");
        apply(64'h8080808080808080, 64'h7F7F7F7F7F7F7F7F, 3'd0);
        check(dot_out, -32'sd130048, "R5 max negative");
        apply(64'h0807060504030201, 64'h0202020202020202, 3'd3);
        check(dot_out, 32'd12, "R1 element order");
        apply(64'h0807060504030201, 64'h0101010101010101, 3'd0);
        check(dot_out, 32'd36, "R3 code zero all terms");

        // R4: tail beyond length 7 altered, result unchanged
        apply(64'h7F01010101010101, 64'h7F02020202020202, 3'd7);
        check(dot_out, 32'd14, "R4 tail baseline");
        apply(64'h8001010101010101, 64'h7F02020202020202, 3'd7);
        check(dot_out, 32'd14, "R4 tail ignored");
        apply(64'hA5C3E781FF7F0103, 64'h80807F7F5A5A1102, 3'd1);
        check(dot_out, 32'd6, "R4 single term tail ignored");

        // R6: output holds until the edge, then updates
        @(negedge clk);
        vec_a = 64'h0000000000000005;
        vec_b = 64'h0000000000000007;
        len_code = 3'd1;
        #1;
        check(dot_out, 32'd6, "R6 holds before edge");
        @(negedge clk);
        check(dot_out, 32'd35, "R6 updates after edge");

        // R7: reset in mid-run clears output
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(dot_out, 32'd0, "R7 reset clears");
        rst = 1'b0;
        @(negedge clk);
        check(dot_out, 32'd35, "R7 resume after reset");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule